// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Set-Less-Than

This block is a purely combinational arithmetic and logic unit of parameter width, built from a column of identical one-bit slices. Each slice can complement either operand bit. It then forms the AND, the OR and a full-adder sum of the two bits, and a small multiplexer picks the slice's output bit from these and from a "less" input. Carries ripple from the lowest slice to the highest.

A 4-bit control word `{inv_a, inv_b, fn_sel[1:0]}` selects the operation. The invert-B bit also drives the carry into the lowest slice, so complementing B gives two's-complement subtraction. Set-less-than takes the raw sign bit of that difference from the top slice and routes it back to the lowest slice's less input. A zero flag tests equality after a subtraction. Carry-out and signed overflow come from the top slice.

Top module: `ripple_alu`

## Requirements
- R1: Control 4'b0000 gives result = a AND b, bitwise.
- R2: Control 4'b0001 gives result = a OR b, bitwise.
- R3: Control 4'b0010 gives result = (a + b) mod 2^W. carry_o is bit W of the unbounded sum.
- R4: Control 4'b0110 gives result = (a + ~b + 1) mod 2^W. carry_o is bit W of a + ~b + 1, so it is 1 exactly when a >= b unsigned.
- R5: Control 4'b1100 gives result = NOT(a OR b), bitwise, formed as the AND of both complemented operands.
- R6: Control 4'b0111 gives a result whose bit 0 equals bit W-1 of (a + ~b + 1) and whose bits W-1..1 are all 0. When the subtraction overflows, this raw sign bit is used without correction.
- R7: zero_o is 1 exactly when every result bit is 0, under every control code. Under subtract it is 1 exactly when a == b.
- R8: Under add, ovf_o is 1 exactly when a and b have the same sign bit and the result's sign bit differs from it.
- R9: Under subtract, ovf_o is 1 exactly when a and b have different sign bits and the result's sign bit differs from that of a.
- R10: Outputs depend only on the present inputs, with no storage. A new input value is reflected on every output within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| ctrl_i | input | 4 | {invert A, invert B, function select[1:0]} |
| result_o | output | W | Operation result |
| zero_o | output | 1 | High when result is all zeros |
| carry_o | output | 1 | Carry out of the most significant slice |
| ovf_o | output | 1 | Signed overflow (carry into MSB slice XOR carry out of it) |

## Verification
All four outputs are combinational, so each is due in the same cycle as the operand and control values that produce it. The bench changes inputs on the falling clock edge and samples one nanosecond after the next rising edge. This leaves a full half period for the ripple chain and the set feedback to settle, and no check depends on the order of events at an edge. Carry and overflow are compared only for add and subtract. Result and zero are compared for all six defined codes.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

    // function select inside every slice
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_SUM  = 2'b10,
        FN_LESS = 2'b11
    } fn_sel_e;

    // full control words {inv_a, inv_b, fn_sel}
    localparam logic [3:0] CTRL_AND = 4'b0000;
    localparam logic [3:0] CTRL_OR  = 4'b0001;
    localparam logic [3:0] CTRL_ADD = 4'b0010;
    localparam logic [3:0] CTRL_SUB = 4'b0110;
    localparam logic [3:0] CTRL_SLT = 4'b0111;
    localparam logic [3:0] CTRL_NOR = 4'b1100;

    typedef struct packed {
        logic res;   // selected output bit
        logic cout;  // carry to next slice
        logic set;   // raw adder sum, used only from the top slice
        logic ovf;   // overflow, only meaningful in the top slice
    } slice_out_t;

endpackage

// File: rtl/ripple_alu_slice.sv
module ripple_alu_slice
    import ripple_alu_pkg::*;
#(
    parameter bit IS_MSB = 1'b0
) (
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       inv_b_i,
    input  fn_sel_e    fn_i,
    input  logic       cin_i,
    input  logic       less_i,
    output slice_out_t out_o
);

    slice_out_t out_d;
    logic       a_eff;
    logic       b_eff;
    logic       sum;

    always_comb begin
        a_eff      = a_i ^ inv_a_i;
        b_eff      = b_i ^ inv_b_i;
        sum        = a_eff ^ b_eff ^ cin_i;
        out_d      = '0;
        out_d.cout = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);
        unique case (fn_i)
            FN_AND:  out_d.res = a_eff & b_eff;
            FN_OR:   out_d.res = a_eff | b_eff;
            FN_SUM:  out_d.res = sum;
            FN_LESS: out_d.res = less_i;
            default: out_d.res = 1'b0;
        endcase
        if (IS_MSB) begin
            out_d.set = sum;
            out_d.ovf = cin_i ^ out_d.cout;
        end
    end

    assign out_o = out_d;

endmodule

// File: rtl/ripple_alu_zero.sv
module ripple_alu_zero #(
    parameter int W = 32
) (
    input  logic [W-1:0] res_i,
    output logic         zero_o
);

    logic zero_d;

    always_comb begin
        zero_d = 1'b1;
        for (int k = 0; k < W; k++) begin
            zero_d = zero_d & ~res_i[k];
        end
    end

    assign zero_o = zero_d;

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ripple_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   ctrl_i,
    output logic [W-1:0] result_o,
    output logic         zero_o,
    output logic         carry_o,
    output logic         ovf_o
);

    localparam int MSB = W - 1;

    logic    inv_a;
    logic    inv_b;
    fn_sel_e fn_sel;
    logic    set_fb;   // sign of the top slice's sum, fed to slice 0

    always_comb begin
        inv_a  = ctrl_i[3];
        inv_b  = ctrl_i[2];
        fn_sel = fn_sel_e'(ctrl_i[1:0]);
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic       cin;
        logic       less;
        slice_out_t so;

        if (i == 0) begin : g_lsb
            assign cin  = inv_b;    // +1 for two's-complement subtract
            assign less = set_fb;
        end else begin : g_mid
            assign cin  = g_bit[i-1].so.cout;
            assign less = 1'b0;
        end

        ripple_alu_slice #(
            .IS_MSB (i == MSB)
        ) slice_i (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (inv_a),
            .inv_b_i (inv_b),
            .fn_i    (fn_sel),
            .cin_i   (cin),
            .less_i  (less),
            .out_o   (so)
        );

        assign result_o[i] = so.res;

        if (i == MSB) begin : g_top
            assign set_fb  = so.set;
            assign carry_o = so.cout;
            assign ovf_o   = so.ovf;
        end
    end

    ripple_alu_zero #(
        .W (W)
    ) zero_i (
        .res_i  (result_o),
        .zero_o (zero_o)
    );

endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk
    import ripple_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   ctrl_i,
    input logic [W-1:0] result_o,
    input logic         zero_o,
    input logic         carry_o,
    input logic         ovf_o
);

    logic [W:0] add_full;
    logic [W:0] sub_full;

    always_comb begin
        add_full = {1'b0, a_i} + {1'b0, b_i};
        sub_full = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};

        if (ctrl_i == CTRL_AND)
            assert_and_R1: assert (result_o == (a_i & b_i));
        if (ctrl_i == CTRL_OR)
            assert_or_R2: assert (result_o == (a_i | b_i));
        if (ctrl_i == CTRL_ADD)
            assert_add_R3: assert ({carry_o, result_o} == add_full);
        if (ctrl_i == CTRL_SUB)
            assert_sub_R4: assert ({carry_o, result_o} == sub_full);
        if (ctrl_i == CTRL_NOR)
            assert_nor_R5: assert (result_o == ~(a_i | b_i));
        if (ctrl_i == CTRL_SLT)
            assert_slt_R6: assert (result_o == {{(W-1){1'b0}}, sub_full[W-1]});
        if (ctrl_i == CTRL_SUB)
            assert_eq_R7: assert (zero_o == (a_i == b_i));
        if (ctrl_i == CTRL_ADD)
            assert_ovf_add_R8: assert (ovf_o ==
                ((a_i[W-1] == b_i[W-1]) && (result_o[W-1] != a_i[W-1])));
        if (ctrl_i == CTRL_SUB)
            assert_ovf_sub_R9: assert (ovf_o ==
                ((a_i[W-1] != b_i[W-1]) && (result_o[W-1] != a_i[W-1])));
    end

endmodule

bind ripple_alu ripple_alu_chk #(.W(W)) chk_i (
    .a_i      (a_i),
    .b_i      (b_i),
    .ctrl_i   (ctrl_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o)
);

// File: tb/ripple_alu_tb_top.sv
module ripple_alu_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   ctrl = 4'b0000;
    logic [W-1:0] result;
    logic         zero;
    logic         carry;
    logic         ovf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ripple_alu #(.W(W)) dut_i (
        .a_i      (a),
        .b_i      (b),
        .ctrl_i   (ctrl),
        .result_o (result),
        .zero_o   (zero),
        .carry_o  (carry),
        .ovf_o    (ovf)
    );

    localparam logic [3:0] OPS [6] = '{4'b0000, 4'b0001, 4'b0010,
                                       4'b0110, 4'b0111, 4'b1100};

    // expected {ovf, carry, result}; computed from the requirements
    function automatic logic [W+1:0] model(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic [3:0]   c);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         v;
        v = 1'b0;
        s = '0;
        r = '0;
        case (c)
            4'b0000: r = x & y;
            4'b0001: r = x | y;
            4'b1100: r = ~(x | y);
            4'b0010: begin
                s = {1'b0, x} + {1'b0, y};
                r = s[W-1:0];
                v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
            end
            4'b0110: begin
                s = {1'b0, x} + {1'b0, ~y} + 1;
                r = s[W-1:0];
                v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
            end
            4'b0111: begin
                s = {1'b0, x} + {1'b0, ~y} + 1;
                r = {{(W-1){1'b0}}, s[W-1]};
            end
            default: r = '0;
        endcase
        return {v, s[W], r};
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic apply_check(input logic [W-1:0] x, input logic [W-1:0] y,
                               input logic [3:0] c);
        logic [W+1:0] e;
        @(negedge clk);
        a = x; b = y; ctrl = c;
        e = model(x, y, c);
        @(posedge clk);
        #1;
        // R10: results due in the same cycle as the inputs
        n_tests++;
        if (result !== e[W-1:0]) begin
            n_fail++;
            $display("FAIL %s/R10 result a=%h b=%h ctrl=%b actual=%h expected=%h",
                     req_of(c), x, y, c, result, e[W-1:0]);
        end
        n_tests++;
        if (zero !== (e[W-1:0] == '0)) begin
            n_fail++;
            $display("FAIL R7 zero a=%h b=%h ctrl=%b actual=%b expected=%b",
                     x, y, c, zero, (e[W-1:0] == '0));
        end
        if (c == 4'b0010 || c == 4'b0110) begin
            n_tests++;
            if (carry !== e[W]) begin
                n_fail++;
                $display("FAIL %s carry a=%h b=%h actual=%b expected=%b",
                         req_of(c), x, y, carry, e[W]);
            end
            n_tests++;
            if (ovf !== e[W+1]) begin
                n_fail++;
                $display("FAIL %s ovf a=%h b=%h actual=%b expected=%b",
                         (c == 4'b0010) ? "R8" : "R9", x, y, ovf, e[W+1]);
            end
        end
    endtask

    initial begin
        logic [W-1:0] x;
        logic [W-1:0] y;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset-state inputs: all zero under AND gives zero result (R1, R7)
        apply_check('0, '0, 4'b0000);

        // directed corners
        apply_check('1, 32'h1, 4'b0010);                 // R3 carry out, zero
        apply_check(32'h7FFF_FFFF, 32'h1, 4'b0010);      // R8 positive overflow
        apply_check(32'h8000_0000, 32'h8000_0000, 4'b0010); // R8 negative overflow
        apply_check(32'h1234_5678, 32'h1234_5678, 4'b0110); // R7 equality
        apply_check('0, '0, 4'b0110);                    // R4 carry with no borrow
        apply_check(32'h0, 32'h1, 4'b0110);              // R4 borrow
        apply_check(32'h8000_0000, 32'h1, 4'b0110);      // R9 overflow
        apply_check(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110); // R9 overflow
        apply_check(32'h8000_0000, 32'h1, 4'b0111);      // R6 raw sign on overflow
        apply_check(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111); // R6 raw sign on overflow
        apply_check(32'hFFFF_FFFF, 32'h0, 4'b0111);      // R6 -1 < 0
        apply_check(32'h5, 32'h5, 4'b0111);              // R6 equal gives 0
        apply_check('0, '0, 4'b1100);                    // R5 all ones
        apply_check(32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'b0001); // R2

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            x = $urandom;
            case ($urandom_range(0, 3))
                0: y = x;
                1: y = ~x;
                2: y = {x[W-1], W'($urandom) >> 1};
                default: y = $urandom;
            endcase
            apply_check(x, y, OPS[$urandom_range(0, 5)]);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule